// File: doc/BRIEF.md
# Down-Counting Timer Channel

A single programmable timer channel for a larger peripheral. Software reaches it through a small word-indexed register window: a reload register reachable at two indices (one reloads the counter at once, the other only changes the value used at the next wrap), a read-only view of the live count, a control byte, raw and masked interrupt status, and a write-only interrupt clear. The counter steps down on strobes from a prescaler. The prescaler divides an external tick enable by 1, 16 or 256.

Three counting modes are supported. Free-running wraps to the all-ones value of the selected width. Periodic wraps to the stored reload value. One-shot stops at zero. The counter is either 16 or 32 bits wide. Reaching zero latches a pending flag, and the single interrupt output is that flag gated by an enable bit. The channel sequencer has three named states. ST_IDLE means the enable bit is clear. ST_COUNT means the channel is counting. ST_EXPIRED means a one-shot has reached zero. Its transitions are: ST_IDLE to ST_COUNT when enable is set; ST_COUNT to ST_IDLE when enable is cleared; ST_COUNT to ST_EXPIRED when a one-shot count reaches zero; ST_EXPIRED to ST_IDLE when enable is cleared; and ST_EXPIRED to ST_COUNT on a write to the immediate-load or control register while enable is still set.

Top module: `tick_timer_chan`

## Requirements
- R1: After reset the control register reads 0x20, the reload and count registers read 0, both status registers read 0 and irq_o is low.
- R2: Control register (index 2) bit layout: bit0 one-shot, bit1 32-bit width, bits 3:2 prescale select, bit5 interrupt enable, bit6 periodic, bit7 enable. Reading it returns bits 7:0 as written, with bit 4 and all upper bits reading 0.
- R3: Prescale select 0 steps the counter on every tick, 1 on every 16th tick, 2 on every 256th tick, and 3 behaves like 0. The tick divider restarts on every control write and whenever the channel is not counting.
- R4: A write to index 0 stores the reload value and replaces the count at once, masked to the active width.
- R5: A write to index 6 stores the reload value and leaves the count untouched. Indices 0 and 6 both read back the full stored reload value.
- R6: Index 1 reads the live count. Writes to it change nothing.
- R7: In periodic mode, a step taken at count 0 loads the reload value, so one period lasts reload+1 steps.
- R8: In free-running mode (bits 0 and 6 both clear), a step at count 0 loads 0xFFFF in 16-bit mode or 0xFFFFFFFF in 32-bit mode, regardless of the reload value.
- R9: In one-shot mode (bit0 wins over bit6), the count halts at zero and ignores further ticks. A write to index 0 restarts it.
- R10: A step that makes the count zero sets the pending flag. Index 4 reads it in bit 0, and index 5 reads it ANDed with the interrupt-enable bit. Any write to index 3 clears it, but a set in the same cycle wins.
- R11: irq_o is high exactly while the pending flag and the interrupt-enable bit are both 1.
- R12: In 16-bit mode only the low 16 count bits step and are tested for zero, and the upper count bits read 0, including right after a switch from 32-bit mode.
- R13: Index 7 reads 0, and writes to it change no register.
- R14: Clearing the enable bit freezes the count at its current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Base tick enable, one clock wide per tick |
| reg_wr_i | input | 1 | Register write strobe |
| reg_idx_i | input | IDX_W (3) | Word index of the accessed register |
| reg_wdata_i | input | DATA_W (32) | Write data |
| reg_rdata_o | output | DATA_W (32) | Read data for reg_idx_i (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
Two collisions can land in one clock. In the first, the counter steps to zero in the same cycle that software writes the interrupt clear. The bench holds the tick and a write to index 3 across the same edge while the count is 1, and it expects the raw status to read 1 afterwards, because the set must win. It then clears again on its own and expects 0. In the second, a tick arrives in the same cycle as an immediate load. Here the load takes priority and no step is taken. The bench exercises this indirectly whenever it restarts a one-shot with a load write.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_EXPIRED
    } tmr_state_e;

    localparam int CTRL_W      = 8;
    localparam int CB_ONESHOT  = 0;
    localparam int CB_WIDE     = 1;
    localparam int CB_PRE_LO   = 2;
    localparam int CB_IE       = 5;
    localparam int CB_PERIODIC = 6;
    localparam int CB_EN       = 7;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;
    localparam logic [CTRL_W-1:0] CTRL_WMASK = 8'hEF;

    localparam int RI_LOAD   = 0;
    localparam int RI_VALUE  = 1;
    localparam int RI_CTRL   = 2;
    localparam int RI_ICLR   = 3;
    localparam int RI_RIS    = 4;
    localparam int RI_MIS    = 5;
    localparam int RI_BGLOAD = 6;

endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int SHIFT_MID = 4,
    parameter int SHIFT_MAX = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       restart_i,
    input  logic       tick_i,
    input  logic [1:0] sel_i,
    output logic       strobe_o
);
    localparam int PRE_W = SHIFT_MAX;
    localparam logic [PRE_W-1:0] MID_MASK = PRE_W'((1 << SHIFT_MID) - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] sel_mask;

    always_comb begin
        unique case (sel_i)
            2'd1:    sel_mask = MID_MASK;
            2'd2:    sel_mask = '1;
            default: sel_mask = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run_i || restart_i) begin
            pre_q <= '0;
        end else if (tick_i) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign strobe_o = run_i && tick_i && !restart_i && ((pre_q & sel_mask) == sel_mask);

    // R3
    div16_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o && sel_i == 2'd1) |=> !strobe_o);

endmodule

// File: rtl/tmr_count_fsm.sv
module tmr_count_fsm
    import tmr_chan_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             oneshot_i,
    input  logic             periodic_i,
    input  logic             wide_i,
    input  logic             strobe_i,
    input  logic             load_wr_i,
    input  logic             ctrl_wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             run_o,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] NARROW_MASK = ~({CNT_W{1'b1}} << NARROW_W);

    tmr_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] mask_cur, mask_new, reload_eff, next_val;
    logic             step_ok, reach_zero;

    assign mask_cur   = wide_i ? '1 : NARROW_MASK;
    assign mask_new   = wdata_i[CB_WIDE] ? '1 : NARROW_MASK;
    assign reload_eff = (oneshot_i || periodic_i) ? (reload_i & mask_cur) : mask_cur;
    assign next_val   = (count_q == '0) ? reload_eff : ((count_q - 1'b1) & mask_cur);
    assign step_ok    = strobe_i && (state_q == ST_COUNT) && !load_wr_i && !ctrl_wr_i;
    assign reach_zero = step_ok && (next_val == '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_i) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (!en_i)                        state_d = ST_IDLE;
                else if (reach_zero && oneshot_i) state_d = ST_EXPIRED;
            end
            ST_EXPIRED: begin
                if (!en_i)                        state_d = ST_IDLE;
                else if (load_wr_i || ctrl_wr_i)  state_d = ST_COUNT;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_wr_i) begin
            count_q <= wdata_i & mask_cur;
        end else if (ctrl_wr_i) begin
            count_q <= count_q & mask_new;
        end else if (step_ok) begin
            count_q <= next_val;
        end
    end

    assign count_o = count_q;
    assign run_o   = (state_q == ST_COUNT);
    assign hit_o   = reach_zero;

    // R3
    strobe_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_i |-> (state_q == ST_COUNT));

    // R12
    narrow_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wide_i |-> ((count_q & ~NARROW_MASK) == '0));

    // R9
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_o && oneshot_i && en_i) |=> (state_q == ST_EXPIRED));

    // R9
    expired_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXPIRED && !load_wr_i && !ctrl_wr_i) |=> (count_q == $past(count_q)));

endmodule

// File: rtl/tmr_pend.sv
module tmr_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic ie_i,
    output logic pend_o,
    output logic irq_o
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     pend_q <= 1'b0;
        else if (set_i) pend_q <= 1'b1;
        else if (clr_i) pend_q <= 1'b0;
    end

    assign pend_o = pend_q;
    assign irq_o  = pend_q & ie_i;

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> pend_o);

    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !pend_o);

endmodule

// File: rtl/tick_timer_chan.sv
module tick_timer_chan
    import tmr_chan_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NARROW_W  = 16,
    parameter int IDX_W     = 3,
    parameter int SHIFT_MID = 4,
    parameter int SHIFT_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              reg_wr_i,
    input  logic [IDX_W-1:0]  reg_idx_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_o
);
    logic [CTRL_W-1:0] ctrl_q;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] count;
    logic              wr_load, wr_bgload, wr_ctrl, wr_iclr;
    logic              run, strobe, hit, pend;

    assign wr_load   = reg_wr_i && (reg_idx_i == IDX_W'(RI_LOAD));
    assign wr_bgload = reg_wr_i && (reg_idx_i == IDX_W'(RI_BGLOAD));
    assign wr_ctrl   = reg_wr_i && (reg_idx_i == IDX_W'(RI_CTRL));
    assign wr_iclr   = reg_wr_i && (reg_idx_i == IDX_W'(RI_ICLR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= CTRL_RESET;
            reload_q <= '0;
        end else begin
            if (wr_ctrl)              ctrl_q   <= reg_wdata_i[CTRL_W-1:0] & CTRL_WMASK;
            if (wr_load || wr_bgload) reload_q <= reg_wdata_i;
        end
    end

    tmr_prescale #(
        .SHIFT_MID (SHIFT_MID),
        .SHIFT_MAX (SHIFT_MAX)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (run),
        .restart_i (wr_ctrl),
        .tick_i    (tick_i),
        .sel_i     (ctrl_q[CB_PRE_LO+1:CB_PRE_LO]),
        .strobe_o  (strobe)
    );

    tmr_count_fsm #(
        .CNT_W    (DATA_W),
        .NARROW_W (NARROW_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (ctrl_q[CB_EN]),
        .oneshot_i  (ctrl_q[CB_ONESHOT]),
        .periodic_i (ctrl_q[CB_PERIODIC]),
        .wide_i     (ctrl_q[CB_WIDE]),
        .strobe_i   (strobe),
        .load_wr_i  (wr_load),
        .ctrl_wr_i  (wr_ctrl),
        .wdata_i    (reg_wdata_i),
        .reload_i   (reload_q),
        .count_o    (count),
        .run_o      (run),
        .hit_o      (hit)
    );

    tmr_pend u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hit),
        .clr_i  (wr_iclr),
        .ie_i   (ctrl_q[CB_IE]),
        .pend_o (pend),
        .irq_o  (irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        case (reg_idx_i)
            IDX_W'(RI_LOAD):   reg_rdata_o = reload_q;
            IDX_W'(RI_BGLOAD): reg_rdata_o = reload_q;
            IDX_W'(RI_VALUE):  reg_rdata_o = count;
            IDX_W'(RI_CTRL):   reg_rdata_o = DATA_W'(ctrl_q);
            IDX_W'(RI_RIS):    reg_rdata_o = DATA_W'(pend);
            IDX_W'(RI_MIS):    reg_rdata_o = DATA_W'(pend & ctrl_q[CB_IE]);
            default:           reg_rdata_o = '0;
        endcase
    end

    // R11
    irq_mis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend && ctrl_q[CB_IE]));

    // R6
    value_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && reg_idx_i == IDX_W'(RI_VALUE) && !strobe) |=> (count == $past(count)));

endmodule

// File: tb/tick_timer_chan_tb.sv
module tick_timer_chan_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tick_timer_chan dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .reg_wr_i    (reg_wr),
        .reg_idx_i   (reg_idx),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_o       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] data);
        @(negedge clk);
        reg_wr = 1'b1; reg_idx = idx[2:0]; reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chk_reg(input string req, input int idx, input logic [31:0] exp);
        reg_idx = idx[2:0];
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic setup(input logic [31:0] cfg, input logic [31:0] ld);
        wr(2, cfg & 32'h7F);
        wr(0, ld);
        wr(3, 0);
        wr(2, cfg);
        idle(1);
    endtask

    task automatic t_reset;
        chk_reg("R1 ctrl", 2, 32'h20);
        chk_reg("R1 load", 0, 32'h0);
        chk_reg("R1 value", 1, 32'h0);
        chk_reg("R1 ris", 4, 32'h0);
        chk_reg("R1 mis", 5, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_ctrl_readback;
        wr(2, 32'h1234_567F);
        chk_reg("R2 ctrl readback", 2, 32'h6F);
        wr(2, 32'h20);
        chk_reg("R2 ctrl restore", 2, 32'h20);
    endtask

    task automatic t_periodic;
        setup(32'hE0, 5);
        chk_reg("R4 load sets value", 1, 5);
        ticks(4);
        chk_reg("R7 count down", 1, 1);
        chk_reg("R10 not yet", 4, 0);
        ticks(1);
        chk_reg("R7 zero", 1, 0);
        chk_reg("R10 ris set", 4, 1);
        chk_reg("R10 mis set", 5, 1);
        chk("R11 irq high", {31'b0, irq}, 1);
        ticks(1);
        chk_reg("R7 reload", 1, 5);
        wr(3, 32'hDEAD);
        chk_reg("R10 cleared", 4, 0);
        chk("R11 irq low", {31'b0, irq}, 0);
    endtask

    task automatic t_bgload;
        setup(32'hE0, 4);
        ticks(1);
        wr(6, 9);
        chk_reg("R5 value kept", 1, 3);
        chk_reg("R5 load readback", 0, 9);
        chk_reg("R5 bgload readback", 6, 9);
        ticks(3);
        chk_reg("R5 zero", 1, 0);
        ticks(1);
        chk_reg("R5 new reload", 1, 9);
    endtask

    task automatic t_value_ro;
        wr(2, 32'h60);
        wr(0, 32'h77);
        wr(1, 32'h1234);
        chk_reg("R6 value write ignored", 1, 32'h77);
        chk_reg("R6 load unchanged", 0, 32'h77);
    endtask

    task automatic t_free16;
        wr(2, 32'h20);
        wr(0, 32'h0001_0002);
        chk_reg("R12 masked load", 1, 32'h2);
        chk_reg("R5 full reload stored", 0, 32'h0001_0002);
        wr(3, 0);
        wr(2, 32'hA0);
        idle(1);
        ticks(2);
        chk_reg("R10 free hits zero", 4, 1);
        ticks(1);
        chk_reg("R8 free 16 wrap", 1, 32'hFFFF);
    endtask

    task automatic t_free32;
        setup(32'hA2, 1);
        ticks(1);
        chk_reg("R8 free32 zero", 1, 0);
        ticks(1);
        chk_reg("R8 free 32 wrap", 1, 32'hFFFF_FFFF);
        wr(2, 32'hA0);
        chk_reg("R12 narrow after switch", 1, 32'hFFFF);
    endtask

    task automatic t_oneshot;
        setup(32'hE1, 3);
        ticks(3);
        chk_reg("R9 reach zero", 1, 0);
        chk_reg("R10 oneshot pend", 4, 1);
        ticks(2);
        chk_reg("R9 stays zero", 1, 0);
        wr(3, 0);
        wr(0, 2);
        chk_reg("R9 restart value", 1, 2);
        ticks(2);
        chk_reg("R9 restart zero", 1, 0);
        chk_reg("R9 restart pend", 4, 1);
    endtask

    task automatic t_set_vs_clear;
        setup(32'hE0, 3);
        ticks(2);
        chk_reg("R10 pre collision", 1, 1);
        @(negedge clk);
        tick = 1'b1; reg_wr = 1'b1; reg_idx = 3'd3; reg_wdata = 0;
        @(negedge clk);
        tick = 1'b0; reg_wr = 1'b0;
        chk_reg("R10 set wins over clear", 4, 1);
        chk_reg("R10 collision value", 1, 0);
        wr(3, 0);
        chk_reg("R10 lone clear", 4, 0);
    endtask

    task automatic t_irq_mask;
        setup(32'hC0, 1);
        ticks(1);
        chk_reg("R10 ris ie off", 4, 1);
        chk_reg("R10 mis ie off", 5, 0);
        chk("R11 irq masked", {31'b0, irq}, 0);
        wr(2, 32'hE0);
        chk("R11 irq unmasked", {31'b0, irq}, 1);
        chk_reg("R10 mis ie on", 5, 1);
        wr(3, 0);
        chk("R11 irq after clear", {31'b0, irq}, 0);
    endtask

    task automatic t_disable;
        setup(32'hE0, 10);
        ticks(3);
        chk_reg("R14 running", 1, 7);
        wr(2, 32'h60);
        ticks(5);
        chk_reg("R14 frozen", 1, 7);
    endtask

    task automatic t_prescale;
        setup(32'hE4, 5);
        ticks(15);
        chk_reg("R3 div16 held", 1, 5);
        ticks(1);
        chk_reg("R3 div16 step", 1, 4);
        setup(32'hE8, 5);
        ticks(255);
        chk_reg("R3 div256 held", 1, 5);
        ticks(1);
        chk_reg("R3 div256 step", 1, 4);
        setup(32'hEC, 5);
        ticks(1);
        chk_reg("R3 sel3 every tick", 1, 4);
    endtask

    task automatic t_unmapped;
        wr(2, 32'h60);
        wr(7, 32'hFFFF_FFFF);
        chk_reg("R13 unmapped read", 7, 0);
        chk_reg("R13 ctrl untouched", 2, 32'h60);
        chk_reg("R13 reload untouched", 0, 5);
    endtask

    task automatic summary;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl_readback();
        t_periodic();
        t_bgload();
        t_value_ro();
        t_free16();
        t_free32();
        t_oneshot();
        t_set_vs_clear();
        t_irq_mask();
        t_disable();
        t_prescale();
        t_unmapped();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
            summary();
            $finish;
        end
    end

endmodule